// File: doc/BRIEF.md
# Load Miss Tracking Table

This block lets an in-order pipeline keep issuing after a load misses in the data cache. Every accepted miss is recorded in a small table together with the register that the load must eventually write. Memory is asked for the block once, and the pipeline moves on. A later miss to a block that is already outstanding joins the existing entry as an extra waiter and sends no second memory request. Each entry has room for a fixed number of waiters.

Memory answers with the index of the entry it is serving. In that same cycle the table reports each waiting destination register on its own writeback strobe, and the entry is released at the next clock edge. The table raises a stall in three cases: an issuing instruction reads a register that still waits for miss data, every entry is occupied, or a miss finds neither a free entry nor room in its block's waiter list.

Each entry is a two-state machine, `ENT_FREE` and `ENT_WAIT`. The transition *alloc* takes `ENT_FREE` to `ENT_WAIT` when a miss to a new block claims the entry. The transition *merge* keeps an entry in `ENT_WAIT` and appends a waiter. The transition *retire* takes `ENT_WAIT` back to `ENT_FREE` when the memory response for that entry arrives.

Top module: `ldmiss_tracker`

## Requirements
- R1: After reset, every entry is free. With idle inputs, `stall`, `miss_accept`, `mem_req_valid` and `wb_valid` are all low.
- R2: A miss to a block that no entry holds, with a free entry available and no stall, is accepted. In the same cycle `mem_req_valid` is high, `mem_req_blk` equals the miss block and `mem_req_idx` is the lowest-numbered free entry.
- R3: A miss to a block held by an entry that is not retiring is accepted with no memory request, and its register is appended as the next waiter. If that entry already has WAITERS waiters, the miss is refused and `stall` is high.
- R4: A response with `resp_valid` high and entry index `resp_idx` drives `wb_valid[k]` high for each waiter k of that entry, in arrival order. `wb_rd` bits [k*REG_W +: REG_W] carry the register number of waiter k. The entry is free from the next cycle.
- R5: `stall` is high while a source with its `src_valid` bit set names a register, other than register 0, that is a waiter of a valid entry. A source naming register 0 never stalls.
- R6: A miss whose destination is register 0 allocates or merges like any other miss but adds no waiter. It never makes a register busy, and a response to an entry holding no waiters raises no writeback strobe.
- R7: While all ENTRIES entries are valid, `stall` is high and no miss is accepted.
- R8: `miss_accept` is high exactly when `miss_valid` is high and `stall` is low.
- R9: The entry named by a response in the current cycle is not a merge target. A miss to its block in that cycle allocates a new entry and issues a new memory request.
- R10: Freed entries are reused lowest index first. Once a middle entry of a full table is freed, the next new-block miss is given that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | A load missed this cycle |
| miss_blk | input | BLK_W | Block address of the missing load |
| miss_rd | input | REG_W | Destination register of the missing load |
| src_valid | input | NSRC | Per-source flag that the issuing instruction reads that source |
| src_rd | input | NSRC*REG_W | Source register numbers of the issuing instruction |
| resp_valid | input | 1 | Memory returns data this cycle |
| resp_idx | input | IDX_W | Entry index the returning data belongs to |
| miss_accept | output | 1 | The miss was recorded; the pipeline continues |
| mem_req_valid | output | 1 | New block request to memory |
| mem_req_blk | output | BLK_W | Block address of the request |
| mem_req_idx | output | IDX_W | Entry index that memory must return with the data |
| wb_valid | output | WAITERS | Per-waiter register writeback strobe |
| wb_rd | output | WAITERS*REG_W | Register number for each writeback strobe |
| stall | output | 1 | Pipeline must hold the issuing instruction |

## Verification
Every output is a combinational function of the inputs and the stored table. `stall`, `miss_accept`, the memory request and the writeback strobes are therefore due in the cycle the stimulus is applied, and the table contents change at the following rising edge. The bench drives inputs on the falling edge and samples the outputs 1 ns later, well before the next rising edge. It advances its own table model only at that rising edge, so each comparison sees the state left by the previous cycle. Directed sequences cover merging, waiter overflow, a full table, a retire during a merge and index reuse. A few thousand cycles of generated traffic over six blocks and eight registers then compare every output against the model.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
    typedef enum logic [0:0] {
        ENT_FREE = 1'b0,
        ENT_WAIT = 1'b1
    } ent_state_e;
endpackage

// File: rtl/lmt_pick.sv
module lmt_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    always_comb begin
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx    = IW'(i);
                onehot = '0;
                onehot[i] = 1'b1;
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/lmt_entry.sv
module lmt_entry import lmt_pkg::*; #(
    parameter int BLK_W   = 26,
    parameter int REG_W   = 5,
    parameter int WAITERS = 2,
    localparam int CNT_W  = $clog2(WAITERS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_i,
    input  logic                     merge_i,
    input  logic                     retire_i,
    input  logic [BLK_W-1:0]         blk_i,
    input  logic [REG_W-1:0]         rd_i,
    output logic                     valid_o,
    output logic [BLK_W-1:0]         blk_o,
    output logic                     room_o,
    output logic [WAITERS-1:0]       wv_o,
    output logic [WAITERS*REG_W-1:0] wrd_o
);
    ent_state_e       st_q, st_d;
    logic [BLK_W-1:0] blk_q;
    logic [CNT_W-1:0] cnt_q;
    logic [REG_W-1:0] rd_q [WAITERS];
    logic             add_rd;

    assign add_rd = (rd_i != '0);

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ENT_FREE: if (alloc_i)  st_d = ENT_WAIT;
            ENT_WAIT: if (retire_i) st_d = ENT_FREE;
            default:                st_d = ENT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ENT_FREE;
        else        st_q <= st_d;
    end

    // block address and waiter list
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= '0;
            cnt_q <= '0;
            for (int w = 0; w < WAITERS; w++) rd_q[w] <= '0;
        end else begin
            if (alloc_i && st_q == ENT_FREE) begin
                blk_q   <= blk_i;
                cnt_q   <= add_rd ? CNT_W'(1) : '0;
                rd_q[0] <= rd_i;
            end else if (merge_i && add_rd && st_q == ENT_WAIT && room_o) begin
                for (int w = 0; w < WAITERS; w++) begin
                    if (cnt_q == CNT_W'(w)) rd_q[w] <= rd_i;
                end
                cnt_q <= cnt_q + CNT_W'(1);
            end else if (retire_i) begin
                cnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        valid_o = (st_q == ENT_WAIT);
        blk_o   = blk_q;
        room_o  = (cnt_q < CNT_W'(WAITERS));
        for (int w = 0; w < WAITERS; w++) begin
            wv_o[w] = valid_o && (CNT_W'(w) < cnt_q);
            wrd_o[w*REG_W +: REG_W] = rd_q[w];
        end
    end

    // R2
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> st_q == ENT_FREE);

    // R2
    alloc_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> (st_q == ENT_WAIT) && (blk_q == $past(blk_i)));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(WAITERS));

    // R3
    full_list_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (merge_i && !room_o && !retire_i) |=> $stable(cnt_q));

    // R4
    retire_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i |=> (st_q == ENT_FREE) && (cnt_q == '0));
endmodule

// File: rtl/lmt_hazard.sv
module lmt_hazard #(
    parameter int ENTRIES = 4,
    parameter int WAITERS = 2,
    parameter int REG_W   = 5,
    parameter int NSRC    = 2
) (
    input  logic [NSRC-1:0]          src_valid,
    input  logic [NSRC*REG_W-1:0]    src_rd,
    input  logic [WAITERS-1:0]       wv  [ENTRIES],
    input  logic [WAITERS*REG_W-1:0] wrd [ENTRIES],
    output logic [NSRC-1:0]          busy
);
    for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
        logic [REG_W-1:0] sr;
        logic             hit;
        assign sr = src_rd[gs*REG_W +: REG_W];
        always_comb begin
            hit = 1'b0;
            for (int e = 0; e < ENTRIES; e++) begin
                for (int w = 0; w < WAITERS; w++) begin
                    if (wv[e][w] && wrd[e][w*REG_W +: REG_W] == sr) hit = 1'b1;
                end
            end
            if (!src_valid[gs] || sr == '0) hit = 1'b0;
        end
        assign busy[gs] = hit;
    end
endmodule

// File: rtl/ldmiss_tracker.sv
module ldmiss_tracker import lmt_pkg::*; #(
    parameter int ENTRIES = 4,
    parameter int WAITERS = 2,
    parameter int BLK_W   = 26,
    parameter int REG_W   = 5,
    parameter int NSRC    = 2,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     miss_valid,
    input  logic [BLK_W-1:0]         miss_blk,
    input  logic [REG_W-1:0]         miss_rd,
    input  logic [NSRC-1:0]          src_valid,
    input  logic [NSRC*REG_W-1:0]    src_rd,
    input  logic                     resp_valid,
    input  logic [IDX_W-1:0]         resp_idx,
    output logic                     miss_accept,
    output logic                     mem_req_valid,
    output logic [BLK_W-1:0]         mem_req_blk,
    output logic [IDX_W-1:0]         mem_req_idx,
    output logic [WAITERS-1:0]       wb_valid,
    output logic [WAITERS*REG_W-1:0] wb_rd,
    output logic                     stall
);
    logic [ENTRIES-1:0]       ent_valid, ent_room, retire_v, match_v;
    logic [ENTRIES-1:0]       alloc_v, merge_v;
    logic [BLK_W-1:0]         ent_blk [ENTRIES];
    logic [WAITERS-1:0]       ent_wv  [ENTRIES];
    logic [WAITERS*REG_W-1:0] ent_wrd [ENTRIES];

    logic               free_any, hit_any;
    logic [IDX_W-1:0]   free_idx, hit_idx;
    logic [ENTRIES-1:0] free_oh, hit_oh;
    logic [NSRC-1:0]    src_busy;
    logic               need_w, room_ok, table_full, use_stall;

    for (genvar ge = 0; ge < ENTRIES; ge++) begin : g_ent
        assign retire_v[ge] = resp_valid && (resp_idx == IDX_W'(ge));
        assign match_v[ge]  = ent_valid[ge] && (ent_blk[ge] == miss_blk) && !retire_v[ge];

        lmt_entry #(
            .BLK_W  (BLK_W),
            .REG_W  (REG_W),
            .WAITERS(WAITERS)
        ) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc_i (alloc_v[ge]),
            .merge_i (merge_v[ge]),
            .retire_i(retire_v[ge]),
            .blk_i   (miss_blk),
            .rd_i    (miss_rd),
            .valid_o (ent_valid[ge]),
            .blk_o   (ent_blk[ge]),
            .room_o  (ent_room[ge]),
            .wv_o    (ent_wv[ge]),
            .wrd_o   (ent_wrd[ge])
        );
    end

    lmt_pick #(.N(ENTRIES)) u_free_pick (
        .req   (~ent_valid),
        .any   (free_any),
        .idx   (free_idx),
        .onehot(free_oh)
    );

    lmt_pick #(.N(ENTRIES)) u_hit_pick (
        .req   (match_v),
        .any   (hit_any),
        .idx   (hit_idx),
        .onehot(hit_oh)
    );

    lmt_hazard #(
        .ENTRIES(ENTRIES),
        .WAITERS(WAITERS),
        .REG_W  (REG_W),
        .NSRC   (NSRC)
    ) u_hazard (
        .src_valid(src_valid),
        .src_rd   (src_rd),
        .wv       (ent_wv),
        .wrd      (ent_wrd),
        .busy     (src_busy)
    );

    always_comb begin
        need_w     = (miss_rd != '0);
        room_ok    = hit_any ? (!need_w || |(hit_oh & ent_room)) : free_any;
        table_full = &ent_valid;
        use_stall  = |src_busy;
        stall      = use_stall || table_full || (miss_valid && !room_ok);
        miss_accept   = miss_valid && !stall;
        mem_req_valid = miss_accept && !hit_any;
        mem_req_blk   = miss_blk;
        mem_req_idx   = free_idx;
        alloc_v = free_oh & {ENTRIES{mem_req_valid}};
        merge_v = hit_oh  & {ENTRIES{miss_accept && hit_any && need_w}};
        wb_valid = resp_valid ? ent_wv[resp_idx]  : '0;
        wb_rd    = resp_valid ? ent_wrd[resp_idx] : '0;
    end

    // R2
    req_claims_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> ent_valid[$past(mem_req_idx)]);

    // R4
    resp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ent_valid[resp_idx]);

    // R4
    resp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !ent_valid[$past(resp_idx)]);

    // R7
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        table_full |-> !mem_req_valid && !miss_accept);

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_v));

    // R9
    retire_not_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(merge_v & retire_v) == 0);
endmodule

// File: tb/ldmiss_tracker_test.sv
`timescale 1ns/1ps
module ldmiss_tracker_test;
    localparam int E = 4, W = 2, BW = 26, RW = 5, NS = 2, IW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mv = 1'b0, rv = 1'b0;
    logic [BW-1:0] mblk = '0;
    logic [RW-1:0] mrd = '0;
    logic [NS-1:0] sv = '0;
    logic [NS*RW-1:0] srd = '0;
    logic [IW-1:0] ri = '0;
    logic acc, req, stl;
    logic [BW-1:0] rblk;
    logic [IW-1:0] ridx;
    logic [W-1:0] wbv;
    logic [W*RW-1:0] wbr;

    always #5 clk = ~clk;

    ldmiss_tracker uut (
        .clk(clk), .rst_n(rst_n), .miss_valid(mv), .miss_blk(mblk), .miss_rd(mrd),
        .src_valid(sv), .src_rd(srd), .resp_valid(rv), .resp_idx(ri),
        .miss_accept(acc), .mem_req_valid(req), .mem_req_blk(rblk), .mem_req_idx(ridx),
        .wb_valid(wbv), .wb_rd(wbr), .stall(stl)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // bench table model
    bit m_v [E];
    int m_blk [E];
    int m_cnt [E];
    int m_rd [E][W];
    bit e_acc, e_req, e_stall, e_hit;
    int e_hidx, e_fidx, e_wbv, e_wbr;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_eval();
        bit full, haz, room;
        int ret;
        full = 1;
        for (int e = 0; e < E; e++) if (!m_v[e]) full = 0;
        haz = 0;
        for (int s = 0; s < NS; s++) begin
            int r = int'(srd[s*RW +: RW]);
            if (sv[s] && r != 0)
                for (int e = 0; e < E; e++)
                    for (int w = 0; w < W; w++)
                        if (m_v[e] && w < m_cnt[e] && m_rd[e][w] == r) haz = 1;
        end
        ret = rv ? int'(ri) : -1;
        e_hit = 0; e_hidx = 0;
        for (int e = 0; e < E; e++)
            if (!e_hit && m_v[e] && m_blk[e] == int'(mblk) && e != ret) begin
                e_hit = 1; e_hidx = e;
            end
        e_fidx = -1;
        for (int e = E - 1; e >= 0; e--) if (!m_v[e]) e_fidx = e;
        room = e_hit ? (mrd == 0 || m_cnt[e_hidx] < W) : (e_fidx >= 0);
        e_stall = haz || full || (mv && !room);
        e_acc = mv && !e_stall;
        e_req = e_acc && !e_hit;
        e_wbv = 0; e_wbr = 0;
        if (rv)
            for (int w = 0; w < m_cnt[ri]; w++) begin
                e_wbv |= (1 << w);
                e_wbr |= (m_rd[ri][w] << (w * RW));
            end
    endtask

    // apply inputs at falling edge, compare 1 ns later
    task automatic drive(string tag, bit imv, int iblk, int ird, bit [1:0] isv,
                         int is0, int is1, bit irv, int iri);
        @(negedge clk);
        mv = imv; mblk = BW'(iblk); mrd = RW'(ird);
        sv = isv; srd = {RW'(is1), RW'(is0)};
        rv = irv; ri = IW'(iri);
        #1;
        model_eval();
        chk({tag, " stall"}, int'(stl), int'(e_stall));
        chk({tag, " accept R8"}, int'(acc), int'(e_acc));
        chk({tag, " memreq"}, int'(req), int'(e_req));
        if (e_req) begin
            chk({tag, " req_idx"}, int'(ridx), e_fidx);
            chk({tag, " req_blk"}, int'(rblk), iblk);
        end
        chk({tag, " wb_valid"}, int'(wbv), e_wbv);
        for (int w = 0; w < W; w++)
            if (e_wbv[w]) chk({tag, " wb_rd"}, int'(wbr[w*RW +: RW]), (e_wbr >> (w*RW)) & 31);
    endtask

    // advance the model at the rising edge
    task automatic tick();
        @(posedge clk);
        if (rv) begin m_v[ri] = 0; m_cnt[ri] = 0; end
        if (e_acc) begin
            if (e_hit) begin
                if (mrd != 0) begin m_rd[e_hidx][m_cnt[e_hidx]] = int'(mrd); m_cnt[e_hidx]++; end
            end else begin
                m_v[e_fidx] = 1; m_blk[e_fidx] = int'(mblk);
                m_cnt[e_fidx] = (mrd != 0) ? 1 : 0;
                m_rd[e_fidx][0] = int'(mrd);
            end
        end
    endtask

    task automatic step(string tag, bit imv, int iblk, int ird, bit [1:0] isv,
                        int is0, int is1, bit irv, int iri);
        drive(tag, imv, iblk, ird, isv, is0, is1, irv, iri);
        tick();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < E; e++) begin m_v[e] = 0; m_cnt[e] = 0; m_blk[e] = 0; end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        drive("R1 idle", 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R1 stall", int'(stl), 0);
        chk("R1 wb", int'(wbv), 0);
        tick();

        // R2 first miss takes entry 0
        drive("R2 alloc", 1, 'h10, 3, 0, 0, 0, 0, 0);
        chk("R2 req", int'(req), 1);
        chk("R2 idx", int'(ridx), 0);
        tick();
        // R3 merge, then overflow
        drive("R3 merge", 1, 'h10, 4, 0, 0, 0, 0, 0);
        chk("R3 merge accept", int'(acc), 1);
        chk("R3 no req", int'(req), 0);
        tick();
        drive("R3 overflow", 1, 'h10, 5, 0, 0, 0, 0, 0);
        chk("R3 overflow stall", int'(stl), 1);
        tick();
        // R6 zero register merges even with a full list
        drive("R6 zero merge", 1, 'h10, 0, 0, 0, 0, 0, 0);
        chk("R6 accept", int'(acc), 1);
        tick();
        // R5 hazards
        drive("R5 busy", 0, 0, 0, 2'b10, 0, 4, 0, 0);
        chk("R5 stall", int'(stl), 1);
        tick();
        drive("R5 zero src", 0, 0, 0, 2'b11, 0, 0, 0, 0);
        chk("R5 zero no stall", int'(stl), 0);
        tick();
        step("R5 unflagged", 0, 0, 0, 2'b00, 3, 4, 0, 0);
        // R6 zero-register new block
        drive("R6 alloc", 1, 'h20, 0, 0, 0, 0, 0, 0);
        chk("R6 idx", int'(ridx), 1);
        tick();
        // R4 + R9: response for entry 0 with a miss to its block
        drive("R4 resp", 1, 'h10, 6, 0, 0, 0, 1, 0);
        chk("R4 wbv", int'(wbv), 3);
        chk("R4 wb0", int'(wbr[4:0]), 3);
        chk("R4 wb1", int'(wbr[9:5]), 4);
        chk("R9 new req", int'(req), 1);
        chk("R9 idx", int'(ridx), 2);
        tick();
        drive("R6 empty resp", 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R6 no wb", int'(wbv), 0);
        tick();
        // R7 fill the table
        step("R7 fill0", 1, 'h30, 1, 0, 0, 0, 0, 0);
        step("R7 fill1", 1, 'h31, 2, 0, 0, 0, 0, 0);
        step("R7 fill3", 1, 'h32, 7, 0, 0, 0, 0, 0);
        drive("R7 full", 1, 'h33, 9, 0, 0, 0, 0, 0);
        chk("R7 stall", int'(stl), 1);
        chk("R7 no accept", int'(acc), 0);
        tick();
        // R10 free middle entry, then reuse
        step("R10 free1", 0, 0, 0, 0, 0, 0, 1, 1);
        drive("R10 reuse", 1, 'h34, 8, 0, 0, 0, 0, 0);
        chk("R10 idx", int'(ridx), 1);
        tick();
        for (int e = 0; e < E; e++) step("R4 drain", 0, 0, 0, 0, 0, 0, 1, e);

        // generated traffic, all requirements against the model
        for (int c = 0; c < 4000; c++) begin
            int pick, st;
            bit prv;
            prv = 0; pick = 0;
            if ($urandom % 3 == 0) begin
                st = int'($urandom % E);
                for (int k = 0; k < E; k++)
                    if (!prv && m_v[(st + k) % E]) begin prv = 1; pick = (st + k) % E; end
            end
            step("R2-sweep R3 R4 R5 R6 R7 R9 R10", ($urandom % 3) != 0, int'($urandom % 6),
                 int'($urandom % 8), 2'($urandom), int'($urandom % 8), int'($urandom % 8),
                 prv, pick);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule